// File: doc/BRIEF.md
# Two-Lane Link Scrambler with Table Keystream

This block whitens, or restores, a 16-bit data path that carries two byte symbols per clock in a serial-link physical layer. It does not step a linear feedback shift register through a wide combinational network. The keystream bytes are computed once at elaboration and held in a constant table, and a byte-position counter indexes that table. The design is a two-stage pipeline. The first stage looks up the key bytes for the current word and registers them with the data. The second stage applies the XOR and registers the result. Because XOR is its own inverse, one instance scrambles on the transmit side and an identical instance descrambles on the receive side.

Each byte lane has a flag that marks the byte as a control symbol. A comma symbol re-aligns the keystream to its starting position. A skip symbol leaves the keystream where it is. Any other control byte uses up one keystream position but passes through unchanged. The table depth is a power of two, set by a parameter, and the position counter wraps when it reaches that depth.

Top module: `lane_scrambler`

## Requirements
- R1: A word presented with `valid_i` high at clock edge k appears with `valid_o` high after edge k+2. `valid_o` is low in every other cycle.
- R2: A byte whose control flag is 0 leaves the block as its value XOR the key byte at the current position. Key byte p comes from a 16-bit shift register seeded 16'hFFFF. Each bit step emits bit 15, shifts left and, if the emitted bit is 1, XORs 16'h0039 (taps x^16+x^5+x^4+x^3+1). Byte p is made of emitted bits 8p to 8p+7, with the first emitted bit in the LSB.
- R3: A byte whose control flag is 1 passes through unchanged, and `ctrl_o` repeats `ctrl_i` with the same latency as the data.
- R4: A control byte equal to 8'hBC (comma) sets the position to 0 for the next byte, whether that byte is in the same word or the next one. The comma itself does not use up a position.
- R5: A control byte equal to 8'h1C (skip) does not advance the position. Every other control byte and every data byte advances it by one.
- R6: Lane 0 (`data_i[7:0]`) is earlier in the sequence than lane 1 (`data_i[15:8]`). A word in which only one lane advances moves the position by one.
- R7: Cycles with `valid_i` low do not change the position.
- R8: The position wraps from 2^POS_W-1 to 0, which restarts the keystream at the seed.
- R9: A second instance fed from the first one's outputs returns the original data and flags four cycles after the input.
- R10: After reset, `valid_o`, `data_o` and `ctrl_o` are 0 and the position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word valid |
| data_i | input | 16 | Two input bytes; lane 0 in the low byte |
| ctrl_i | input | 2 | Per-lane control-symbol flag |
| valid_o | output | 1 | Output word valid |
| data_o | output | 16 | Scrambled or descrambled bytes |
| ctrl_o | output | 2 | Delayed per-lane control flags |

## Verification
The assertions check four behaviours on every cycle: the two-cycle valid latency, that control bytes and flags pass through unchanged, that the position holds during idle cycles, and that a comma in the last lane clears the position. The bench scenarios are needed for the rest, because each expected byte depends on the whole history of positions. That covers the keystream values themselves, the way skip, comma and other control symbols share out positions between the two lanes, wrap-around at the table depth, and the scramble-then-descramble round trip. These are compared against a bit-serial register model.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam logic [15:0] LFSR_SEED = 16'hFFFF;
  localparam logic [15:0] LFSR_TAPS = 16'h0039;

  // advance eight bit steps; returns {next_state, key_byte}
  function automatic logic [23:0] lfsr_byte(input logic [15:0] st);
    logic [15:0] s;
    logic [7:0]  k;
    s = st;
    k = '0;
    for (int b = 0; b < 8; b++) begin
      k[b] = s[15];
      s    = s[15] ? ((s << 1) ^ LFSR_TAPS) : (s << 1);
    end
    return {s, k};
  endfunction
endpackage

// File: rtl/scr_key_rom.sv
module scr_key_rom #(
  parameter int POS_W = 8,
  localparam int DEPTH = 1 << POS_W
) (
  output logic [DEPTH-1:0][7:0] table_o
);
  // constant table, folded at elaboration
  always_comb begin
    logic [15:0] st;
    logic [23:0] r;
    st = scr_pkg::LFSR_SEED;
    for (int i = 0; i < DEPTH; i++) begin
      r          = scr_pkg::lfsr_byte(st);
      table_o[i] = r[7:0];
      st         = r[23:8];
    end
  end
endmodule

// File: rtl/scr_seq_gen.sv
module scr_seq_gen #(
  parameter int          LANES   = 2,
  parameter int          POS_W   = 8,
  parameter logic [7:0]  COM_SYM = 8'hBC,
  parameter logic [7:0]  SKP_SYM = 8'h1C,
  localparam int DW    = 8 * LANES,
  localparam int DEPTH = 1 << POS_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [DW-1:0]         data_i,
  input  logic [LANES-1:0]      ctrl_i,
  input  logic [DEPTH-1:0][7:0] key_tbl_i,
  output logic                  s1_valid_o,
  output logic [DW-1:0]         s1_data_o,
  output logic [LANES-1:0]      s1_ctrl_o,
  output logic [DW-1:0]         s1_key_o,
  output logic [LANES-1:0]      s1_en_o,
  output logic [POS_W-1:0]      pos_o
);
  logic [POS_W-1:0]         pos_q;
  logic [LANES:0][POS_W-1:0] lane_pos;
  logic [DW-1:0]            key_w;

  assign lane_pos[0] = pos_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] byte_w;
    logic       is_com, is_skp;
    assign byte_w = data_i[8*l +: 8];
    assign is_com = ctrl_i[l] && (byte_w == COM_SYM);
    assign is_skp = ctrl_i[l] && (byte_w == SKP_SYM);
    assign key_w[8*l +: 8] = key_tbl_i[lane_pos[l]];
    assign lane_pos[l+1] = !valid_i ? lane_pos[l] :
                           is_com   ? '0 :
                           is_skp   ? lane_pos[l] : lane_pos[l] + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q      <= '0;
      s1_valid_o <= 1'b0;
      s1_data_o  <= '0;
      s1_ctrl_o  <= '0;
      s1_key_o   <= '0;
      s1_en_o    <= '0;
    end else begin
      pos_q      <= lane_pos[LANES];
      s1_valid_o <= valid_i;
      if (valid_i) begin
        s1_data_o <= data_i;
        s1_ctrl_o <= ctrl_i;
        s1_key_o  <= key_w;
        s1_en_o   <= ~ctrl_i;
      end
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/scr_xor_stage.sv
module scr_xor_stage #(
  parameter int LANES = 2,
  localparam int DW = 8 * LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s1_valid_i,
  input  logic [DW-1:0]    s1_data_i,
  input  logic [LANES-1:0] s1_ctrl_i,
  input  logic [DW-1:0]    s1_key_i,
  input  logic [LANES-1:0] s1_en_i,
  output logic             valid_o,
  output logic [DW-1:0]    data_o,
  output logic [LANES-1:0] ctrl_o
);
  logic [DW-1:0] mask_w;

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign mask_w[8*l +: 8] = s1_key_i[8*l +: 8] & {8{s1_en_i[l]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      ctrl_o  <= '0;
    end else begin
      valid_o <= s1_valid_i;
      if (s1_valid_i) begin
        data_o <= s1_data_i ^ mask_w;
        ctrl_o <= s1_ctrl_i;
      end
    end
  end
endmodule

// File: rtl/lane_scrambler.sv
module lane_scrambler #(
  parameter int         LANES   = 2,
  parameter int         POS_W   = 8,
  parameter logic [7:0] COM_SYM = 8'hBC,
  parameter logic [7:0] SKP_SYM = 8'h1C,
  localparam int DW    = 8 * LANES,
  localparam int DEPTH = 1 << POS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [DW-1:0]    data_i,
  input  logic [LANES-1:0] ctrl_i,
  output logic             valid_o,
  output logic [DW-1:0]    data_o,
  output logic [LANES-1:0] ctrl_o
);
  logic [DEPTH-1:0][7:0] key_tbl;
  logic                  s1_valid;
  logic [DW-1:0]         s1_data;
  logic [LANES-1:0]      s1_ctrl;
  logic [DW-1:0]         s1_key;
  logic [LANES-1:0]      s1_en;
  logic [POS_W-1:0]      pos_q;

  scr_key_rom #(.POS_W(POS_W)) u_rom (.table_o(key_tbl));

  scr_seq_gen #(
    .LANES(LANES), .POS_W(POS_W), .COM_SYM(COM_SYM), .SKP_SYM(SKP_SYM)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .data_i     (data_i),
    .ctrl_i     (ctrl_i),
    .key_tbl_i  (key_tbl),
    .s1_valid_o (s1_valid),
    .s1_data_o  (s1_data),
    .s1_ctrl_o  (s1_ctrl),
    .s1_key_o   (s1_key),
    .s1_en_o    (s1_en),
    .pos_o      (pos_q)
  );

  scr_xor_stage #(.LANES(LANES)) u_xor (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .s1_valid_i (s1_valid),
    .s1_data_i  (s1_data),
    .s1_ctrl_i  (s1_ctrl),
    .s1_key_i   (s1_key),
    .s1_en_i    (s1_en),
    .valid_o    (valid_o),
    .data_o     (data_o),
    .ctrl_o     (ctrl_o)
  );
endmodule

// File: rtl/lane_scrambler_chk.sv
module lane_scrambler_chk #(
  parameter int         LANES   = 2,
  parameter int         POS_W   = 8,
  parameter logic [7:0] COM_SYM = 8'hBC,
  localparam int DW = 8 * LANES
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [DW-1:0]    data_i,
  input logic [LANES-1:0] ctrl_i,
  input logic             valid_o,
  input logic [DW-1:0]    data_o,
  input logic [LANES-1:0] ctrl_o,
  input logic             s1_valid,
  input logic [POS_W-1:0] pos_q
);
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (valid_o == $past(valid_i, 2))); // R1

  AST_STAGE_HANDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid |=> valid_o); // R1

  AST_CTRL_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2 && valid_o) |-> (ctrl_o == $past(ctrl_i, 2))); // R3

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    AST_CTRL_BYTE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q == 2'd2 && valid_o && ctrl_o[l]) |->
        (data_o[8*l +: 8] == $past(data_i[8*l +: 8], 2))); // R3
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pos_q)); // R7

  AST_COMMA_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctrl_i[LANES-1] && data_i[DW-1 -: 8] == COM_SYM) |=> (pos_q == '0)); // R4
endmodule

bind lane_scrambler lane_scrambler_chk #(
  .LANES(LANES), .POS_W(POS_W), .COM_SYM(COM_SYM)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
  .ctrl_i(ctrl_i), .valid_o(valid_o), .data_o(data_o), .ctrl_o(ctrl_o),
  .s1_valid(s1_valid), .pos_q(pos_q)
);

// File: tb/lane_scrambler_test.sv
`timescale 1ns/1ps
module lane_scrambler_test;
  localparam int POS_W = 8;
  localparam int DEPTH = 1 << POS_W;
  localparam logic [7:0] COM = 8'hBC;
  localparam logic [7:0] SKP = 8'h1C;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] data_i = '0;
  logic [1:0]  ctrl_i = '0;
  logic        valid_o, rx_valid;
  logic [15:0] data_o, rx_data;
  logic [1:0]  ctrl_o, rx_ctrl;

  always #2.5 clk = ~clk;

  lane_scrambler #(.POS_W(POS_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .ctrl_i(ctrl_i), .valid_o(valid_o), .data_o(data_o), .ctrl_o(ctrl_o)
  );

  lane_scrambler #(.POS_W(POS_W)) uut_rx (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_o), .data_i(data_o),
    .ctrl_i(ctrl_o), .valid_o(rx_valid), .data_o(rx_data), .ctrl_o(rx_ctrl)
  );

  int checks = 0, fails = 0, cyc = 0, mpos = 0;
  string req = "R2";
  logic        ev [8];
  logic [15:0] ed [8], id [8];
  logic [1:0]  ec [8];
  bit done = 0;

  // bit-serial reference of the keystream byte at a position
  function automatic logic [7:0] ref_key(input int pos);
    logic [15:0] s = 16'hFFFF;
    logic [7:0]  k = '0;
    for (int n = 0; n < 8 * (pos + 1); n++) begin
      logic fb = s[15];
      if (n >= 8 * pos) k[n - 8*pos] = fb;
      s = {s[14:0], fb};
      if (fb) begin s[3] = ~s[3]; s[4] = ~s[4]; s[5] = ~s[5]; end
    end
    return k;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", r, cyc, act, exp);
    end
  endtask

  task automatic check_outputs();
    if (cyc >= 2) begin
      int s = (cyc - 2) % 8;
      chk("R1", {31'd0, valid_o}, {31'd0, ev[s]});
      if (ev[s]) begin
        chk(req, {16'd0, data_o}, {16'd0, ed[s]});
        chk("R3", {30'd0, ctrl_o}, {30'd0, ec[s]});
      end
    end
    if (cyc >= 4) begin
      int s = (cyc - 4) % 8;
      chk("R9", {31'd0, rx_valid}, {31'd0, ev[s]});
      if (ev[s]) chk("R9", {14'd0, rx_ctrl, rx_data}, {14'd0, ec[s], id[s]});
    end
  endtask

  task automatic step(input logic v, input logic [15:0] d, input logic [1:0] c);
    int s;
    @(negedge clk);
    check_outputs();
    s = cyc % 8;
    ev[s] = v; id[s] = d; ec[s] = c; ed[s] = d;
    if (v) begin
      for (int l = 0; l < 2; l++) begin
        logic [7:0] b = d[8*l +: 8];
        if (c[l]) begin
          if (b == COM)      mpos = 0;
          else if (b != SKP) mpos = (mpos + 1) % DEPTH;
        end else begin
          ed[s][8*l +: 8] = b ^ ref_key(mpos);
          mpos = (mpos + 1) % DEPTH;
        end
      end
    end
    valid_i = v; data_i = d; ctrl_i = c;
    cyc++;
  endtask

  function automatic logic [7:0] rnd_ctrl_byte();
    int r = $urandom_range(2);
    return (r == 0) ? COM : (r == 1) ? SKP : 8'hF7;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10", {15'd0, valid_o, data_o}, 32'd0);
    chk("R10", {30'd0, ctrl_o}, 32'd0);
    rst_ni = 1'b1;

    // R10/R2: position 0 right after reset; zeros expose raw keystream
    req = "R10";
    step(1, 16'h0000, 2'b00);
    req = "R2";
    for (int i = 0; i < 6; i++) step(1, 16'h0000, 2'b00);
    step(1, {8'h00, COM}, 2'b01);
    for (int i = 0; i < 4; i++) step(1, 16'hFFFF, 2'b00);

    // R6: lane order with plain data
    req = "R6";
    for (int i = 0; i < 20; i++) step(1, 16'($urandom), 2'b00);

    // R5: skip holds position, other control advances, single-lane advance
    req = "R5";
    step(1, {8'h5A, SKP}, 2'b01);
    step(1, {SKP, 8'hA5}, 2'b10);
    step(1, {SKP, SKP}, 2'b11);
    step(1, {8'h33, 8'hF7}, 2'b01);
    step(1, {8'hF7, 8'h44}, 2'b10);
    step(1, 16'h1234, 2'b00);

    // R4: comma in lane 0 and in lane 1
    req = "R4";
    step(1, {8'h00, COM}, 2'b01);
    step(1, 16'h0000, 2'b00);
    step(1, {COM, 8'h77}, 2'b10);
    step(1, 16'h0000, 2'b00);
    step(1, {COM, COM}, 2'b11);
    step(1, 16'h9999, 2'b00);

    // R7: idle cycles carry garbage but do not move the position
    req = "R7";
    for (int i = 0; i < 12; i++) step(i % 3 == 0, 16'($urandom), 2'($urandom));
    step(1, 16'h0000, 2'b00);

    // R8: run past the table depth twice
    req = "R8";
    step(1, {8'h00, COM}, 2'b01);
    for (int i = 0; i < DEPTH + 20; i++) step(1, 16'($urandom), 2'b00);

    // mixed random traffic, checked also through the round trip
    req = "R9";
    for (int i = 0; i < 4000; i++) begin
      logic [1:0]  c = '0;
      logic [15:0] d = 16'($urandom);
      if ($urandom_range(9) == 0) begin c[0] = 1'b1; d[7:0]  = rnd_ctrl_byte(); end
      if ($urandom_range(9) == 0) begin c[1] = 1'b1; d[15:8] = rnd_ctrl_byte(); end
      step($urandom_range(4) != 0, d, c);
    end
    for (int i = 0; i < 6; i++) step(0, 16'h0000, 2'b00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule